// File: doc/BRIEF.md
# CPU Core Power-Up Sequencer

This block brings a secondary processor core out of power collapse under hardware control. A single-cycle start pulse launches a fixed release order. The block first requests the core supply rail through a voltage-control word. It waits for the rail to settle. It then steps a 9-bit power-control word through a set of bit changes: clamps on and array sleep released, power-on reset pulsed, clamp dropped, and finally the core marked as powered up. Each step has its own minimum settle time.

Every register update appears as a one-cycle write strobe with the value on a data bus. Downstream logic, or a bench, can therefore see the exact write order and the cycle spacing between writes. All settle times come from a clock-frequency parameter, rounded up to whole cycles with a floor of one cycle. A busy flag covers the run. A done pulse marks the final write.

Top module: `core_pwrup_seq`

## Requirements
- R1: While `rst` is high at a clock edge, both data buses go to zero and `busy`, `done`, `vctl_we` and `pctl_we` go low, with the sequencer idle.
- R2: A `start` high in idle produces, one cycle later, a single `vctl_we` strobe with `vctl_data` = 0xA4, and `busy` high in that same cycle.
- R3: After the rail request the block writes exactly six `pctl_data` values, in this order: 0x109, 0x101, 0x121, 0x120, 0x100, 0x180. The bit meanings are: bit 8 PLL clamp, bit 7 core powered up, bit 5 power-on reset, bit 4 core reset, bit 3 L2 data/tag sleep, bit 0 clamp.
- R4: The gap in cycles between consecutive strobes is set by the settle time of the step before the gap. Each settle time is converted to cycles as max(1, ceil(t·CLK_HZ)). The gaps and their settle times are:
  - rail request to first power write: 512 µs
  - first power write to second: no settle time (1 cycle)
  - second to third: 300 ns
  - third to fourth: 2 µs
  - fourth to fifth: 2 µs
  - fifth to sixth: 100 µs
- R5: Bit 4 (core reset) is zero on every power-control write.
- R6: `done` is high for exactly one cycle, the cycle of the final power write. `busy` is high from the rail-request cycle up to, but not including, that cycle.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The write count, values and spacing are unchanged.
- R8: After `done`, `pctl_data` holds 0x180 and `vctl_data` holds 0xA4, with no further strobes, until a reset or a new start.
- R9: A reset in the middle of the sequence aborts it. The outputs are zero after the reset edge, and no strobes follow until the next start, which runs a complete sequence.
- R10: At most one write strobe is high in any cycle. `pctl_data` changes only in a cycle with `pctl_we` or after a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin the power-up sequence |
| vctl_we | output | 1 | Voltage-control write strobe |
| vctl_data | output | 8 | Voltage-control word |
| pctl_we | output | 1 | Power-control write strobe |
| pctl_data | output | 9 | Power-control word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on the final write |

## Verification
The bench builds the block with CLK_HZ = 3 MHz. At this clock the rail wait is 1536 cycles and the 100 µs wait is 300 cycles, so several full runs fit in a short simulation. The 300 ns step rounds 0.9 cycles up to one cycle, which exercises the ceiling rule. The 2 µs steps come out at exactly six cycles, so a loose rounding error also shows up. The small clock also allows a sweep that drives `start` in every busy cycle of a run, and an abort by reset part-way through the waits.

// File: rtl/cpwr_pkg.sv
package cpwr_pkg;

    localparam int VCTL_W = 8;
    localparam int PCTL_W = 9;
    localparam int STEP_W = 3;
    localparam int N_PCTL_WRITES = 6;

    // Power-control bit positions (decoded by the core power logic)
    localparam int B_PLL_CLAMP = 8;
    localparam int B_PWRD_UP   = 7;
    localparam int B_POR       = 5;
    localparam int B_CORE_RST  = 4;
    localparam int B_L2_SLEEP  = 3;
    localparam int B_CLAMP     = 0;

    localparam logic [VCTL_W-1:0] RAIL_ON_CODE = 8'hA4;

    // Settle times in nanoseconds
    localparam longint unsigned T_RAIL_NS  = 512_000;
    localparam longint unsigned T_TAG_NS   = 300;
    localparam longint unsigned T_POR_NS   = 2_000;
    localparam longint unsigned T_UNCLP_NS = 2_000;
    localparam longint unsigned T_REL_NS   = 100_000;

    typedef enum logic {
        PH_IDLE,
        PH_WAIT
    } phase_e;

    function automatic longint unsigned ns_to_cycles(longint unsigned ns,
                                                     longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

    typedef struct packed {
        phase_e              phase;
        logic [STEP_W-1:0]   step;
        logic                vctl_we;
        logic [VCTL_W-1:0]   vctl_data;
        logic                pctl_we;
        logic [PCTL_W-1:0]   pctl_data;
        logic                busy;
        logic                done;
    } seq_state_t;

endpackage

// File: rtl/cpwr_wait_timer.sv
module cpwr_wait_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cpwr_step_table.sv
module cpwr_step_table
    import cpwr_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 200_000_000,
    parameter int              CNT_W  = 17
) (
    input  logic [STEP_W-1:0] idx,
    output logic [PCTL_W-1:0] pctl_val,
    output logic [CNT_W-1:0]  wait_m1,
    output logic              last,
    output logic [CNT_W-1:0]  rail_m1
);

    localparam longint unsigned C_RAIL  = ns_to_cycles(T_RAIL_NS, CLK_HZ);
    localparam longint unsigned C_TAG   = ns_to_cycles(T_TAG_NS, CLK_HZ);
    localparam longint unsigned C_POR   = ns_to_cycles(T_POR_NS, CLK_HZ);
    localparam longint unsigned C_UNCLP = ns_to_cycles(T_UNCLP_NS, CLK_HZ);
    localparam longint unsigned C_REL   = ns_to_cycles(T_REL_NS, CLK_HZ);

    localparam logic [PCTL_W-1:0] V_ALL_CLAMP =
        PCTL_W'((1 << B_PLL_CLAMP) | (1 << B_L2_SLEEP) | (1 << B_CLAMP));
    localparam logic [PCTL_W-1:0] V_TAG_AWAKE = V_ALL_CLAMP & ~PCTL_W'(1 << B_L2_SLEEP);
    localparam logic [PCTL_W-1:0] V_POR_ON    = V_TAG_AWAKE | PCTL_W'(1 << B_POR);
    localparam logic [PCTL_W-1:0] V_UNCLAMP   = V_POR_ON & ~PCTL_W'(1 << B_CLAMP);
    localparam logic [PCTL_W-1:0] V_POR_OFF   = V_UNCLAMP & ~PCTL_W'(1 << B_POR);
    localparam logic [PCTL_W-1:0] V_PWRD      = V_POR_OFF | PCTL_W'(1 << B_PWRD_UP);

    assign rail_m1 = CNT_W'(C_RAIL - 1);

    always_comb begin
        pctl_val = '0;
        wait_m1  = '0;
        last     = 1'b0;
        case (idx)
            3'd1: begin pctl_val = V_ALL_CLAMP; wait_m1 = '0;                  end
            3'd2: begin pctl_val = V_TAG_AWAKE; wait_m1 = CNT_W'(C_TAG - 1);   end
            3'd3: begin pctl_val = V_POR_ON;    wait_m1 = CNT_W'(C_POR - 1);   end
            3'd4: begin pctl_val = V_UNCLAMP;   wait_m1 = CNT_W'(C_UNCLP - 1); end
            3'd5: begin pctl_val = V_POR_OFF;   wait_m1 = CNT_W'(C_REL - 1);   end
            3'd6: begin pctl_val = V_PWRD;      last = 1'b1;                   end
            default: begin end
        endcase
    end

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
    import cpwr_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 200_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              vctl_we,
    output logic [VCTL_W-1:0] vctl_data,
    output logic              pctl_we,
    output logic [PCTL_W-1:0] pctl_data,
    output logic              busy,
    output logic              done
);

    // The rail wait is the longest; size the counter from it.
    localparam longint unsigned RAIL_CYC = ns_to_cycles(T_RAIL_NS, CLK_HZ);
    localparam int CNT_W = (RAIL_CYC > 2) ? $clog2(RAIL_CYC) : 1;

    seq_state_t s_d, s_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [PCTL_W-1:0] tbl_val;
    logic [CNT_W-1:0] tbl_wait_m1;
    logic [CNT_W-1:0] tbl_rail_m1;
    logic             tbl_last;

    cpwr_step_table #(
        .CLK_HZ (CLK_HZ),
        .CNT_W  (CNT_W)
    ) u_table (
        .idx      (s_q.step),
        .pctl_val (tbl_val),
        .wait_m1  (tbl_wait_m1),
        .last     (tbl_last),
        .rail_m1  (tbl_rail_m1)
    );

    cpwr_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        s_d         = s_q;
        s_d.vctl_we = 1'b0;
        s_d.pctl_we = 1'b0;
        s_d.done    = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.vctl_we   = 1'b1;
                    s_d.vctl_data = RAIL_ON_CODE;
                    s_d.busy      = 1'b1;
                    s_d.step      = STEP_W'(1);
                    s_d.phase     = PH_WAIT;
                    tmr_load      = 1'b1;
                    tmr_val       = tbl_rail_m1;
                end
            end
            PH_WAIT: begin
                if (tmr_expired) begin
                    s_d.pctl_we   = 1'b1;
                    s_d.pctl_data = tbl_val;
                    if (tbl_last) begin
                        s_d.done  = 1'b1;
                        s_d.busy  = 1'b0;
                        s_d.step  = '0;
                        s_d.phase = PH_IDLE;
                    end else begin
                        s_d.step  = s_q.step + 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = tbl_wait_m1;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{phase: PH_IDLE, step: '0, vctl_we: 1'b0, vctl_data: '0,
                     pctl_we: 1'b0, pctl_data: '0, busy: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign vctl_we   = s_q.vctl_we;
    assign vctl_data = s_q.vctl_data;
    assign pctl_we   = s_q.pctl_we;
    assign pctl_data = s_q.pctl_data;
    assign busy      = s_q.busy;
    assign done      = s_q.done;

endmodule

// File: rtl/cpwr_seq_checker.sv
module cpwr_seq_checker
    import cpwr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              vctl_we,
    input logic [VCTL_W-1:0] vctl_data,
    input logic              pctl_we,
    input logic [PCTL_W-1:0] pctl_data,
    input logic              busy,
    input logic              done
);

    p_rail_code_r2: assert property (@(posedge clk) disable iff (rst)
        vctl_we |-> vctl_data == RAIL_ON_CODE);

    p_rail_first_r3: assert property (@(posedge clk) disable iff (rst)
        pctl_we |-> vctl_data == RAIL_ON_CODE);

    p_no_core_rst_r5: assert property (@(posedge clk) disable iff (rst)
        pctl_we |-> !pctl_data[B_CORE_RST]);

    p_done_final_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (pctl_we && pctl_data[B_PWRD_UP] && !busy));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !vctl_we);

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !(vctl_we && pctl_we));

    p_pctl_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pctl_data != $past(pctl_data)) |-> (pctl_we || $past(rst)));

endmodule

bind core_pwrup_seq cpwr_seq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .vctl_we   (vctl_we),
    .vctl_data (vctl_data),
    .pctl_we   (pctl_we),
    .pctl_data (pctl_data),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_core_pwrup_seq.sv
module tb_core_pwrup_seq;

    localparam longint unsigned HZ = 3_000_000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       vctl_we, pctl_we, busy, done;
    logic [7:0] vctl_data;
    logic [8:0] pctl_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    core_pwrup_seq #(.CLK_HZ(HZ)) dut (
        .clk(clk), .rst(rst), .start(start),
        .vctl_we(vctl_we), .vctl_data(vctl_data),
        .pctl_we(pctl_we), .pctl_data(pctl_data),
        .busy(busy), .done(done)
    );

    always #2.5 clk = ~clk;   // 200 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // Write log filled by the monitor only
    int         n_wr = 0;
    int         log_cyc  [64];
    logic       log_pctl [64];
    logic [8:0] log_data [64];
    int         busy_cnt = 0;
    int         done_cnt = 0;
    int         done_cyc = 0;
    int         bit4_cnt = 0;
    int         both_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if ((vctl_we || pctl_we) && n_wr < 64) begin
                log_cyc[n_wr]  <= cyc;
                log_pctl[n_wr] <= pctl_we;
                log_data[n_wr] <= pctl_we ? pctl_data : {1'b0, vctl_data};
                n_wr <= n_wr + 1;
            end
            if (vctl_we && pctl_we) both_cnt <= both_cnt + 1;
            if (pctl_we && pctl_data[4]) bit4_cnt <= bit4_cnt + 1;
            if (busy) busy_cnt <= busy_cnt + 1;
            if (done) begin
                done_cnt <= done_cnt + 1;
                done_cyc <= cyc;
            end
        end
    end

    longint unsigned wexp [6];
    logic [8:0]      pexp [6];
    longint unsigned wsum;

    function automatic longint unsigned cyc_of(longint unsigned ns);
        longint unsigned c;
        c = (ns * HZ + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // One full run; inject=1 drives start in every busy cycle
    task automatic run_seq(input bit inject, input string tag);
        int b_wr, b_busy, b_done, s_cyc;
        b_wr   = n_wr;
        b_busy = busy_cnt;
        b_done = done_cnt;
        @(negedge clk);
        start = 1'b1;
        s_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        while (!done) begin
            start = inject && busy;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(n_wr - b_wr == 7, {tag, " R7 write count"}, n_wr - b_wr, 7);
        chk(log_cyc[b_wr] - s_cyc == 1, {tag, " R2 rail latency"}, log_cyc[b_wr] - s_cyc, 1);
        chk(!log_pctl[b_wr] && log_data[b_wr] == 9'h0A4, {tag, " R2 rail code"},
            log_data[b_wr], 'hA4);
        for (int k = 0; k < 6; k++) begin
            chk(log_pctl[b_wr+1+k] && log_data[b_wr+1+k] == pexp[k], {tag, " R3 pctl value"},
                log_data[b_wr+1+k], pexp[k]);
            chk(log_cyc[b_wr+1+k] - log_cyc[b_wr+k] == int'(wexp[k]), {tag, " R4 spacing"},
                log_cyc[b_wr+1+k] - log_cyc[b_wr+k], wexp[k]);
        end
        chk(done_cnt - b_done == 1, {tag, " R6 done count"}, done_cnt - b_done, 1);
        chk(done_cyc == log_cyc[b_wr+6], {tag, " R6 done cycle"}, done_cyc, log_cyc[b_wr+6]);
        chk(busy_cnt - b_busy == int'(wsum), {tag, " R6 busy span"}, busy_cnt - b_busy, wsum);
        chk(bit4_cnt == 0, {tag, " R5 core reset bit"}, bit4_cnt, 0);
        chk(both_cnt == 0, {tag, " R10 one strobe"}, both_cnt, 0);
    endtask

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int b;
        wexp[0] = cyc_of(512_000);
        wexp[1] = 1;
        wexp[2] = cyc_of(300);
        wexp[3] = cyc_of(2_000);
        wexp[4] = cyc_of(2_000);
        wexp[5] = cyc_of(100_000);
        wsum = 0;
        for (int k = 0; k < 6; k++) wsum += wexp[k];
        pexp[0] = 9'h109; pexp[1] = 9'h101; pexp[2] = 9'h121;
        pexp[3] = 9'h120; pexp[4] = 9'h100; pexp[5] = 9'h180;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk(vctl_data == 0 && pctl_data == 0, "R1 buses zero", pctl_data, 0);
        chk(!busy && !done && !vctl_we && !pctl_we, "R1 flags low",
            {busy, done, vctl_we, pctl_we}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        run_seq(1'b0, "plain");

        // R8 hold after done
        b = n_wr;
        repeat (50) @(negedge clk);
        chk(pctl_data == 9'h180, "R8 pctl hold", pctl_data, 'h180);
        chk(vctl_data == 8'hA4, "R8 vctl hold", vctl_data, 'hA4);
        chk(n_wr == b && !busy, "R8 no strobes", n_wr - b, 0);

        run_seq(1'b1, "sweep");

        // R9 abort by reset partway through the 100 us wait
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(pctl_we && pctl_data == 9'h100)) @(negedge clk);
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(pctl_data == 0 && vctl_data == 0, "R9 buses cleared", pctl_data, 0);
        chk(!busy && !done, "R9 idle flags", busy, 0);
        b = n_wr;
        repeat (400) @(negedge clk);
        chk(n_wr == b, "R9 no strobes after abort", n_wr - b, 0);
        chk(pctl_data == 0, "R10 pctl stable without strobe", pctl_data, 0);

        run_seq(1'b0, "after_abort");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule